// File: doc/BRIEF.md
# I2C SCL Phase Timing Generator

This block produces the SCL waveform for an I2C master. A prescaler divides the parent clock into ticks. A sample counter groups the ticks into sample periods. A step counter groups the sample periods into the low phase and the high phase. Each phase has its own sample count and its own step count, so the low and high times can differ.

Five 16-bit timing registers are loaded through a single-cycle write port: clock divider, high timing, low timing, high-speed timing and extension. The `hs_sel_i` input chooses between the standard/fast field set and the high-speed field set.

While `en_i` is high, the block drives SCL low during the low phase and releases it during the high phase. It pulses `sample_o` at the end of each sample period. It also reports the START setup length that the extension register selects. The protocol engine around the block handles bytes, ACK and SDA.

Every count field holds its value minus one, so a field value of N gives N+1 units. Configuration is captured at the start of each SCL period, so a write never shortens or stretches a phase that is already running.

Top module: `i2c_scl_phase_gen`

## Requirements
- R1: After reset, and in every cycle that follows a clock edge at which `en_i` was low, `scl_low_o` and `sample_o` are 0. `setup_o` is 0 after reset.
- R2: After `en_i` is sampled high, the low phase runs first. `scl_low_o` is 1 for exactly (div+1)*(smp_lo+1)*(stp_lo+1) clock cycles, starting in the cycle after that edge.
- R3: The high phase follows the low phase. `scl_low_o` is 0 for exactly (div+1)*(smp_hi+1)*(stp_hi+1) cycles, and then the next low phase begins.
- R4: `sample_o` is a one-cycle pulse in the last cycle of each sample period. One SCL period gives (stp_lo+1)+(stp_hi+1) pulses.
- R5: Standard/fast set (`hs_sel_i`=0), by write address:
  - address 0, bits 7:0: div.
  - address 1 (high timing): bits 10:8 smp_hi, bits 5:0 stp_hi.
  - address 2 (low timing): bits 8:6 smp_lo, bits 5:0 stp_lo.
- R6: High-speed set (`hs_sel_i`=1):
  - address 0, bits 15:8: div.
  - address 3: bits 14:12 smp_hi, bits 10:8 stp_hi.
  - address 2: bits 14:12 smp_lo, bits 11:9 stp_lo.
- R7: Address 4 is the extension register and bit 0 enables the START setup count. In standard/fast mode `setup_o` = bits 15:8 plus 1, which reaches a maximum of 256. In high-speed mode it is bits 7:1 plus 1. When bit 0 is 0, `setup_o` is 0.
- R8: Register writes and changes of `hs_sel_i` made while running take effect at the start of the next SCL period. The period in progress keeps its old lengths.
- R9: Writes to addresses 5 to 7 change no register.
- R10: When `en_i` is dropped, SCL is released from the next cycle on. A later enable restarts with a complete low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run the SCL generator |
| hs_sel_i | input | 1 | 1 selects the high-speed field set |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 16 | Register write data |
| scl_low_o | output | 1 | 1 drives SCL low |
| sample_o | output | 1 | End-of-sample-period strobe |
| setup_o | output | 9 | START setup length in parent clock ticks, 0 when disabled |

## Verification
The bench uses the package's default field widths: an 8-bit divider, 3-bit sample counts, 6-bit standard step counts and 3-bit high-speed step counts. With small field values, a full SCL period fits in a few dozen cycles. This lets the bench count every low and high cycle and every strobe exactly. It covers both phase orders of unequal length, a non-zero prescaler, both register sets, and a write issued on the enable edge, which falls inside the first period. The largest extension field, 255, is within reach and checks the 256 cap.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int DIV_W     = 8;
  localparam int SMP_W     = 3;
  localparam int STEP_W    = 6;
  localparam int HS_STEP_W = 3;
  localparam int SU_W      = 9;
  localparam int N_REGS    = 5;

  localparam logic [ADDR_W-1:0] A_DIV  = 3'd0;
  localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
  localparam logic [ADDR_W-1:0] A_LTIM = 3'd2;
  localparam logic [ADDR_W-1:0] A_HS   = 3'd3;
  localparam logic [ADDR_W-1:0] A_EXT  = 3'd4;

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [SMP_W-1:0]  smp_lo;
    logic [SMP_W-1:0]  smp_hi;
    logic [STEP_W-1:0] stp_lo;
    logic [STEP_W-1:0] stp_hi;
    logic [SU_W-1:0]   setup;
  } scl_cfg_t;
endpackage

// File: rtl/i2c_scl_regs.sv
module i2c_scl_regs
  import i2c_scl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hs_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output scl_cfg_t          cfg_o
);
  logic [N_REGS-1:0][REG_W-1:0] regs_q;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))   regs_q[i] <= wr_data_i;
    end
  end

  logic [REG_W-1:0] r_div, r_htim, r_ltim, r_hs, r_ext;
  assign r_div  = regs_q[A_DIV];
  assign r_htim = regs_q[A_HTIM];
  assign r_ltim = regs_q[A_LTIM];
  assign r_hs   = regs_q[A_HS];
  assign r_ext  = regs_q[A_EXT];

  always_comb begin
    cfg_o = '0;
    if (hs_sel_i) begin
      cfg_o.div    = r_div[15:8];
      cfg_o.smp_hi = r_hs[14:12];
      cfg_o.stp_hi = STEP_W'(r_hs[8 +: HS_STEP_W]);
      cfg_o.smp_lo = r_ltim[14:12];
      cfg_o.stp_lo = STEP_W'(r_ltim[9 +: HS_STEP_W]);
      cfg_o.setup  = r_ext[0] ? SU_W'(r_ext[7:1]) + SU_W'(1) : '0;
    end else begin
      cfg_o.div    = r_div[DIV_W-1:0];
      cfg_o.smp_hi = r_htim[8 +: SMP_W];
      cfg_o.stp_hi = r_htim[STEP_W-1:0];
      cfg_o.smp_lo = r_ltim[6 +: SMP_W];
      cfg_o.stp_lo = r_ltim[STEP_W-1:0];
      cfg_o.setup  = r_ext[0] ? SU_W'(r_ext[15:8]) + SU_W'(1) : '0;
    end
  end

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= ADDR_W'(N_REGS)) |=> $stable(regs_q)); // R9
endmodule

// File: rtl/i2c_scl_prescaler.sv
module i2c_scl_prescaler
  import i2c_scl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_PRE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= div_i); // R2
endmodule

// File: rtl/i2c_scl_phase.sv
module i2c_scl_phase
  import i2c_scl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     tick_i,
  input  scl_cfg_t cfg_next_i,
  output scl_cfg_t cfg_o,
  output logic     run_o,
  output logic     scl_low_o,
  output logic     sample_o
);
  scl_cfg_t          cfg_q;
  logic              run_q, high_q;
  logic [SMP_W-1:0]  smp_q;
  logic [STEP_W-1:0] stp_q;
  logic [SMP_W-1:0]  cur_smp;
  logic [STEP_W-1:0] cur_stp;
  logic              smp_end, phase_end;

  assign cur_smp   = high_q ? cfg_q.smp_hi : cfg_q.smp_lo;
  assign cur_stp   = high_q ? cfg_q.stp_hi : cfg_q.stp_lo;
  assign smp_end   = run_q && tick_i && (smp_q == cur_smp);
  assign phase_end = smp_end && (stp_q == cur_stp);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      high_q <= 1'b0;
      smp_q  <= '0;
      stp_q  <= '0;
    end else if (!en_i || !run_q) begin
      cfg_q  <= cfg_next_i;
      run_q  <= en_i;
      high_q <= 1'b0;
      smp_q  <= '0;
      stp_q  <= '0;
    end else if (tick_i) begin
      if (!smp_end) begin
        smp_q <= smp_q + SMP_W'(1);
      end else begin
        smp_q <= '0;
        if (!phase_end) begin
          stp_q <= stp_q + STEP_W'(1);
        end else begin
          stp_q  <= '0;
          high_q <= ~high_q;
          if (high_q) cfg_q <= cfg_next_i; // period boundary
        end
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign run_o     = run_q;
  assign scl_low_o = run_q && !high_q;
  assign sample_o  = smp_end;

  AST_LOW_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> !high_q); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !phase_end) |=> $stable(high_q)); // R3
  AST_SAMPLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> tick_i); // R4
  AST_SMP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (smp_q <= cur_smp && stp_q <= cur_stp)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && en_i && !(phase_end && high_q)) |=> $stable(cfg_q)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (!scl_low_o && !sample_o)); // R1
endmodule

// File: rtl/i2c_scl_phase_gen.sv
module i2c_scl_phase_gen
  import i2c_scl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hs_sel_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              scl_low_o,
  output logic              sample_o,
  output logic [SU_W-1:0]   setup_o
);
  scl_cfg_t cfg_next, cfg_act;
  logic     run, tick;

  i2c_scl_regs u_regs (
    .clk_i, .rst_ni, .hs_sel_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cfg_o(cfg_next)
  );

  i2c_scl_prescaler u_pre (
    .clk_i, .rst_ni, .run_i(run), .div_i(cfg_act.div), .tick_o(tick)
  );

  i2c_scl_phase u_phase (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .cfg_next_i(cfg_next),
    .cfg_o(cfg_act), .run_o(run), .scl_low_o, .sample_o
  );

  assign setup_o = cfg_act.setup;
endmodule

// File: tb/i2c_scl_phase_gen_bench.sv
module i2c_scl_phase_gen_bench;
  logic        clk = 0, rst_ni = 0, en = 0, hs = 0, wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        scl_low, sample;
  logic [8:0]  setup;
  int errors = 0, checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  i2c_scl_phase_gen u_i2c_scl_phase_gen (
    .clk_i(clk), .rst_ni, .en_i(en), .hs_sel_i(hs), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .scl_low_o(scl_low), .sample_o(sample), .setup_o(setup)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // called at the negedge of the first low cycle; leaves at the next one
  task automatic measure(output int l, output int h, output int s);
    l = 0; h = 0; s = 0;
    while (scl_low)  begin l++; s += int'(sample); @(negedge clk); end
    while (!scl_low) begin h++; s += int'(sample); @(negedge clk); end
  endtask

  task automatic start_run();
    @(negedge clk); en = 1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    @(negedge clk); en = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 scl_low", int'(scl_low), 0);
    chk("R1 sample", int'(sample), 0);
    chk("R1 setup", int'(setup), 0);
  endtask

  task automatic t_normal();
    int l, h, s;
    // div=0, smp_lo=1 stp_lo=3, smp_hi=1 stp_hi=1
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0101); wr(3'd2, 16'h0043);
    start_run();
    measure(l, h, s);
    chk("R2 low len", l, 8); chk("R3 high len", h, 4); chk("R4 samples", s, 6);
    measure(l, h, s);
    chk("R3 second low", l, 8); chk("R5 second high", h, 4);
    stop_run();
  endtask

  task automatic t_prescale();
    int l, h, s;
    // div=2, smp_lo=0 stp_lo=2, smp_hi=0 stp_hi=2
    wr(3'd0, 16'h0002); wr(3'd1, 16'h0002); wr(3'd2, 16'h0002);
    start_run();
    measure(l, h, s);
    chk("R2 prescaled low", l, 9); chk("R3 prescaled high", h, 9);
    chk("R4 prescaled samples", s, 6);
    stop_run();
  endtask

  task automatic t_hs();
    int l, h, s;
    // hs div=1; hs reg smp_hi=1 stp_hi=2; ltim hs smp_lo=0 stp_lo=4
    wr(3'd0, 16'h0100); wr(3'd3, 16'h1200); wr(3'd2, 16'h0800);
    hs = 1;
    start_run();
    measure(l, h, s);
    chk("R6 hs low", l, 10); chk("R6 hs high", h, 12); chk("R4 hs samples", s, 8);
    stop_run();
    hs = 0;
  endtask

  task automatic t_boundary();
    int l, h, s;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    // write lands on the enable edge: first period keeps old values
    @(negedge clk); en = 1; wr_en = 1; wr_addr = 3'd2; wr_data = 16'h0005;
    @(negedge clk); wr_en = 0;
    measure(l, h, s);
    chk("R8 old low kept", l, 2); chk("R8 old high kept", h, 2);
    measure(l, h, s);
    chk("R8 new low", l, 6); chk("R8 high unchanged", h, 2);
    stop_run();
  endtask

  task automatic t_unmapped();
    int l, h, s;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0001); wr(3'd2, 16'h0001);
    wr(3'd5, 16'hFFFF); wr(3'd6, 16'hFFFF); wr(3'd7, 16'hFFFF);
    start_run();
    measure(l, h, s);
    chk("R9 low after unmapped", l, 2); chk("R9 high after unmapped", h, 2);
    stop_run();
  endtask

  task automatic t_setup();
    wr(3'd4, 16'h2A00); repeat (2) @(negedge clk);
    chk("R7 setup disabled", int'(setup), 0);
    wr(3'd4, 16'h2A01); repeat (2) @(negedge clk);
    chk("R7 setup normal", int'(setup), 43);
    wr(3'd4, 16'hFF01); repeat (2) @(negedge clk);
    chk("R7 setup cap", int'(setup), 256);
    wr(3'd4, 16'h001B); hs = 1; repeat (2) @(negedge clk);
    chk("R7 setup hs", int'(setup), 14);
    hs = 0; repeat (2) @(negedge clk);
  endtask

  task automatic t_stop();
    int l, h, s;
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0003); wr(3'd2, 16'h0003);
    start_run();
    @(negedge clk);
    en = 0;
    @(negedge clk);
    chk("R10 released", int'(scl_low), 0);
    chk("R1 no sample idle", int'(sample), 0);
    start_run();
    measure(l, h, s);
    chk("R10 restart low", l, 4);
    stop_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_prescale();
    t_hs();
    t_boundary();
    t_unmapped();
    t_setup();
    t_stop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule